// File: doc/BRIEF.md
# Interrupt Selector With Drop Detection

This block steers system events onto a small set of maskable CPU interrupt lines. Each of the 12 interrupt lines picks one of 128 event inputs through a 7-bit event number. The event numbers sit in three 32-bit selector registers, four byte-wide lanes per register. Every interrupt line keeps a pending flag. The flag is set when its selected event fires and cleared when the CPU acknowledges that line with a strobe.

When a selected event fires on a line whose pending flag is still up, that interrupt has been lost. The block keeps a record of the first such loss: the line number and the event number that caused it. It also emits a one-cycle error event. That error event is fed back into event input 96, so it can itself be routed to an interrupt line. Later losses leave the record unchanged until software writes the clear bit.

Events are sampled every clock. Each cycle that an event input is high counts as one arrival.

Top module: `evt_irq_router`

## Requirements
- R1: After reset, all pending flags, `drop_stat_o` and `err_evt_o` are zero, and every selector field holds event number 0, so event 0 reaches all 12 lines.
- R2: Interrupt line i listens to the 7-bit event number held in selector register i/4 (written with `cfg_addr_i` = i/4, values 0 to 2), bits 8*(i%4)+6 down to 8*(i%4). Bit 7 of each byte lane is ignored.
- R3: A pending flag rises at the first clock edge at which its selected event is high. A flag never rises without its selected event.
- R4: An `ack_i` bit clears its pending flag at the next edge. If the selected event and the acknowledge arrive in the same cycle, the flag stays set.
- R5: A drop is a selected event arriving while the line's flag is set and that line is not acknowledged in the same cycle. At the edge where a drop is seen with no record held, `drop_stat_o` takes the value: bit 15 = 1, bits 11:8 = line number, bits 6:0 = event number, all other bits 0.
- R6: `err_evt_o` is high for exactly the one cycle that follows the edge at which a drop is captured.
- R7: While a record is held, further drops change neither `drop_stat_o` nor `err_evt_o`.
- R8: A write to `cfg_addr_i` = 3 with `cfg_wdata_i[0]` = 1 resets `drop_stat_o` to zero at that edge. The same write with bit 0 = 0 has no effect. If a drop is seen in the same cycle as the clear, the new drop is recorded.
- R9: If several lines drop in the same cycle, the lowest-numbered line is recorded.
- R10: `err_evt_o` acts as event input 96 in the cycle it is high. A line selecting event 96 becomes pending at the edge that ends the error pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 128 | System event inputs, one arrival per high cycle |
| ack_i | input | 12 | Per-line pending-flag clear strobes |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 2 | 0 to 2: selector registers; 3: drop clear |
| cfg_wdata_i | input | 32 | Configuration write data |
| irq_pend_o | output | 12 | Pending flag per interrupt line |
| drop_stat_o | output | 16 | Drop record: valid, line number, event number |
| err_evt_o | output | 1 | One-cycle error event on first drop |

## Verification
Pending flags, the drop record and the error pulse are all due one clock edge after the cycle that carries the causing event, acknowledge or write. The event-96 feedback shows up on a pending flag one edge later still. The bench changes inputs on the falling edge and samples outputs on the falling edge that follows the next rising edge. Each expected value is therefore read exactly one edge after its stimulus. For the feedback, the bench checks both the cycle in which the pulse is high, where the flag is still clear, and the cycle after, where the flag is set.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned NUM_EVT   = 128;
  localparam int unsigned EVT_W     = $clog2(NUM_EVT);
  localparam int unsigned NUM_IRQ   = 12;
  localparam int unsigned IRQ_W     = 4;
  localparam int unsigned LANES     = 4;
  localparam int unsigned LANE_W    = 8;
  localparam int unsigned DATA_W    = LANES * LANE_W;
  localparam int unsigned NUM_SEL   = (NUM_IRQ + LANES - 1) / LANES;
  localparam int unsigned ADDR_W    = 2;
  localparam int unsigned CLR_ADDR  = 3;
  localparam int unsigned ERR_EVT   = 96;
  localparam int unsigned STAT_W    = 16;
  localparam int unsigned STAT_VLD  = 15;
  localparam int unsigned STAT_IRQ  = 8;

  typedef struct packed {
    logic             valid;
    logic [IRQ_W-1:0] irq;
    logic [EVT_W-1:0] evt;
  } drop_rec_t;
endpackage

// File: rtl/evt_sel_regs.sv
module evt_sel_regs
  import evt_irq_pkg::*;
#(
  parameter int unsigned N_IRQ = NUM_IRQ,
  parameter int unsigned SEL_W = EVT_W,
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned DW    = DATA_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [AW-1:0]              addr_i,
  input  logic [DW-1:0]              wdata_i,
  output logic [N_IRQ-1:0][SEL_W-1:0] sel_o
);
  localparam int unsigned N_LANE = DW / LANE_W;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_field
    localparam int unsigned REG_IDX = i / N_LANE;
    localparam int unsigned LSB     = LANE_W * (i % N_LANE);
    logic hit;
    assign hit = we_i && (addr_i == AW'(REG_IDX));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  sel_o[i] <= '0;
      else if (hit) sel_o[i] <= wdata_i[LSB +: SEL_W];
    end
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import evt_irq_pkg::*;
#(
  parameter int unsigned N_IRQ = NUM_IRQ,
  parameter int unsigned N_EVT = NUM_EVT,
  parameter int unsigned SEL_W = EVT_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_EVT-1:0]            evt_i,
  input  logic [N_IRQ-1:0][SEL_W-1:0] sel_i,
  input  logic [N_IRQ-1:0]            ack_i,
  output logic [N_IRQ-1:0]            pend_o,
  output logic [N_IRQ-1:0]            drop_o
);
  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    logic hit, keep;
    assign hit  = evt_i[sel_i[i]];
    assign keep = pend_o[i] & ~ack_i[i];
    // acked flag hands over cleanly; only an unserviced flag loses the event
    assign drop_o[i] = hit & keep;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_o[i] <= 1'b0;
      else         pend_o[i] <= hit | keep;
    end
  end
endmodule

// File: rtl/drop_recorder.sv
module drop_recorder
  import evt_irq_pkg::*;
#(
  parameter int unsigned N_IRQ = NUM_IRQ,
  parameter int unsigned SEL_W = EVT_W,
  parameter int unsigned ID_W  = IRQ_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_IRQ-1:0]            drop_i,
  input  logic [N_IRQ-1:0][SEL_W-1:0] sel_i,
  input  logic                        clr_i,
  output drop_rec_t                   rec_o,
  output logic                        err_o
);
  logic             any_drop;
  logic [ID_W-1:0]  win_id;
  logic [SEL_W-1:0] win_evt;
  logic             take;

  assign any_drop = |drop_i;

  // lowest line wins: scan downward so the last write is the lowest index
  always_comb begin
    win_id  = '0;
    win_evt = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (drop_i[i]) begin
        win_id  = ID_W'(i);
        win_evt = sel_i[i];
      end
    end
  end

  assign take = any_drop && (!rec_o.valid || clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_o <= '0;
      err_o <= 1'b0;
    end else begin
      err_o <= take;
      if (take)       rec_o <= '{valid: 1'b1, irq: win_id, evt: win_evt};
      else if (clr_i) rec_o <= '0;
    end
  end
endmodule

// File: rtl/evt_irq_router.sv
module evt_irq_router
  import evt_irq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_EVT-1:0]  evt_i,
  input  logic [NUM_IRQ-1:0]  ack_i,
  input  logic                cfg_we_i,
  input  logic [ADDR_W-1:0]   cfg_addr_i,
  input  logic [DATA_W-1:0]   cfg_wdata_i,
  output logic [NUM_IRQ-1:0]  irq_pend_o,
  output logic [STAT_W-1:0]   drop_stat_o,
  output logic                err_evt_o
);
  logic [NUM_IRQ-1:0][EVT_W-1:0] sel;
  logic [NUM_EVT-1:0]            evt_all;
  logic [NUM_IRQ-1:0]            drop_vec;
  logic                          clr_req;
  drop_rec_t                     rec;
  logic                          unused_wdata;

  always_comb begin
    evt_all          = evt_i;
    evt_all[ERR_EVT] = evt_i[ERR_EVT] | err_evt_o;
  end

  assign clr_req      = cfg_we_i && (cfg_addr_i == ADDR_W'(CLR_ADDR)) && cfg_wdata_i[0];
  assign unused_wdata = ^{cfg_wdata_i[31], cfg_wdata_i[23], cfg_wdata_i[15], cfg_wdata_i[7]};

  evt_sel_regs u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .sel_o   (sel)
  );

  irq_pend_bank u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_all),
    .sel_i  (sel),
    .ack_i  (ack_i),
    .pend_o (irq_pend_o),
    .drop_o (drop_vec)
  );

  drop_recorder u_rec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .drop_i (drop_vec),
    .sel_i  (sel),
    .clr_i  (clr_req),
    .rec_o  (rec),
    .err_o  (err_evt_o)
  );

  always_comb begin
    drop_stat_o                             = '0;
    drop_stat_o[STAT_VLD]                   = rec.valid;
    drop_stat_o[STAT_IRQ +: IRQ_W]          = rec.irq;
    drop_stat_o[EVT_W-1:0]                  = rec.evt;
  end
endmodule

// File: rtl/evt_irq_router_chk.sv
module evt_irq_router_chk
  import evt_irq_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_EVT-1:0] evt_i,
  input logic [NUM_IRQ-1:0] ack_i,
  input logic [NUM_IRQ-1:0] irq_pend_o,
  input logic [STAT_W-1:0]  drop_stat_o,
  input logic               err_evt_o,
  input logic               clr_i,
  input logic               drop_any_i
);
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_evt_o |=> !err_evt_o); // R6

  AST_ERR_HAS_RECORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_evt_o |-> drop_stat_o[STAT_VLD]); // R5

  AST_RECORD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_stat_o[STAT_VLD] && !clr_i) |=> ($stable(drop_stat_o) && !err_evt_o)); // R7

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !drop_any_i) |=> (drop_stat_o == '0)); // R8

  AST_ACK_ALL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&ack_i) && (evt_i == '0) && !err_evt_o) |=> (irq_pend_o == '0)); // R4

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_i == '0) && !err_evt_o) |=> ((irq_pend_o & ~$past(irq_pend_o)) == '0)); // R3
endmodule

bind evt_irq_router evt_irq_router_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_i       (evt_i),
  .ack_i       (ack_i),
  .irq_pend_o  (irq_pend_o),
  .drop_stat_o (drop_stat_o),
  .err_evt_o   (err_evt_o),
  .clr_i       (clr_req),
  .drop_any_i  (|drop_vec)
);

// File: tb/evt_irq_router_tb_top.sv
`timescale 1ns/1ps
module evt_irq_router_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [127:0] evt_i = '0;
  logic [11:0]  ack_i = '0;
  logic         cfg_we_i = 1'b0;
  logic [1:0]   cfg_addr_i = '0;
  logic [31:0]  cfg_wdata_i = '0;
  logic [11:0]  irq_pend_o;
  logic [15:0]  drop_stat_o;
  logic         err_evt_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  evt_irq_router dut_i (
    .clk_i, .rst_ni, .evt_i, .ack_i, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .irq_pend_o, .drop_stat_o, .err_evt_o
  );

  typedef struct packed {
    logic [1:0]  addr;
    logic [31:0] data;
    logic [6:0]  evt;
    logic [11:0] exp;
  } vec_t;

  // applied in order; selector registers carry over between rows
  localparam vec_t VECS [6] = '{
    '{2'd0, 32'h0000_0000, 7'd0,   12'hFFF},  // R1 reset selectors all 0
    '{2'd0, 32'h2A1B_0C05, 7'd12,  12'h002},
    '{2'd1, 32'h7F40_4142, 7'd127, 12'h080},
    '{2'd2, 32'h6363_6363, 7'd99,  12'hF00},
    '{2'd2, 32'h8D0D_0D8D, 7'd13,  12'hF00},  // bit 7 of lanes ignored
    '{2'd0, 32'h0505_0505, 7'd5,   12'h00F}
  };

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic pulse(input logic [127:0] e, input logic [11:0] a);
    evt_i = e;
    ack_i = a;
    tick();
    evt_i = '0;
    ack_i = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cfg_we_i = 1'b1;
    cfg_addr_i = a;
    cfg_wdata_i = d;
    tick();
    cfg_we_i = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] ev(input int n);
    logic [127:0] v = '0;
    v[n] = 1'b1;
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 pend", 32'(irq_pend_o), 32'h0);
    chk("R1 stat", 32'(drop_stat_o), 32'h0);
    chk("R1 err", 32'(err_evt_o), 32'h0);

    for (int k = 0; k < 6; k++) begin
      pulse('0, 12'hFFF);
      wr(VECS[k].addr, VECS[k].data);
      pulse(ev(int'(VECS[k].evt)), '0);
      chk("R2 map", 32'(irq_pend_o), 32'(VECS[k].exp));
    end

    // lines 0..10 -> events 0..10, line 11 -> 96
    wr(2'd0, 32'h0302_0100);
    wr(2'd1, 32'h0706_0504);
    wr(2'd2, 32'h600A_0908);
    pulse('0, 12'hFFF);
    chk("R4 ack all", 32'(irq_pend_o), 32'h0);

    pulse(ev(1), '0);
    chk("R3 set", 32'(irq_pend_o), 32'h002);
    pulse(ev(1), 12'h002);
    chk("R4 set wins", 32'(irq_pend_o), 32'h002);
    chk("R5 acked no drop", 32'(drop_stat_o), 32'h0);
    pulse('0, 12'h002);
    chk("R4 clear", 32'(irq_pend_o), 32'h0);

    pulse(ev(2), '0);
    chk("R3 set2", 32'(irq_pend_o), 32'h004);
    pulse(ev(2), '0);
    chk("R5 record", 32'(drop_stat_o), 32'h8202);
    chk("R6 err high", 32'(err_evt_o), 32'h1);
    chk("R10 not yet", 32'(irq_pend_o), 32'h004);
    tick();
    chk("R6 err low", 32'(err_evt_o), 32'h0);
    chk("R10 fed back", 32'(irq_pend_o), 32'h804);

    pulse(ev(3), '0);
    pulse(ev(3), '0);
    chk("R7 held", 32'(drop_stat_o), 32'h8202);
    chk("R7 no err", 32'(err_evt_o), 32'h0);

    wr(2'd3, 32'h0000_0000);
    chk("R8 bit0 zero", 32'(drop_stat_o), 32'h8202);
    wr(2'd3, 32'h0000_0001);
    chk("R8 cleared", 32'(drop_stat_o), 32'h0);

    pulse('0, 12'hFFF);
    pulse(ev(5) | ev(6) | ev(9), '0);
    chk("R3 multi", 32'(irq_pend_o), 32'h260);
    pulse(ev(5) | ev(6) | ev(9), '0);
    chk("R9 lowest", 32'(drop_stat_o), 32'h8505);
    chk("R6 err again", 32'(err_evt_o), 32'h1);
    tick();
    chk("R10 again", 32'(irq_pend_o), 32'hA60);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule